// File: doc/BRIEF.md
# Segmented Linearity Error Estimator

This block estimates the integral nonlinearity of a converter under a ramp test without keeping one histogram bin per code. Each sample pairs the code the converter produced with the code an ideal converter would have produced. The produced code is cut into three equal bit fields: low, middle and high. For every value of every field, the block keeps a running sum of the difference (ideal minus produced) and a count of the samples that carried that field value.

When the stream ends, a done strobe starts a single shared divider. The divider turns each of the 48 sums into a mean error in signed fixed point with four fractional bits, one term after another. Once all terms are stored, a ready flag rises. From then on, a query port returns the estimate for any code one cycle after the code is presented. The estimate is the sum of that code's low-field, middle-field and high-field terms. A start strobe clears everything so that a new run can begin.

Top module: `seg_inl_est`

## Requirements
- R1: The produced code is split as low field = bits [3:0], middle field = bits [7:4], high field = bits [11:8]. An accepted sample adds (ideal − produced) to the sum of each of its three field values and adds one to the count of each.
- R2: Each term equals 16·sum/count truncated toward zero. It is stored as a signed value in units of 1/16 code.
- R3: A field value that no accepted sample carried gives a term of zero.
- R4: `qry_inl_o` shows, one cycle after `qry_code_i` is applied, the sum of the low-, middle- and high-field terms of that code, as a 20-bit two's-complement number in units of 1/16 code.
- R5: `start_i` clears all sums, counts and terms and drops `ready_o` on the next cycle. Collection resumes from that cycle.
- R6: `done_i`, while collecting, begins the term computation. Samples and further `done_i` pulses that arrive during the computation are ignored.
- R7: `ready_o` rises within 2000 cycles of `done_i`, once all 48 terms are stored. It stays high until `start_i`.
- R8: Samples that arrive while `ready_o` is high change no term.
- R9: After reset, the block collects, `ready_o` is low and every term is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clear all state and begin a new run |
| done_i | input | 1 | End of stream; begin term computation |
| sample_vld_i | input | 1 | Sample strobe |
| act_code_i | input | 12 | Code produced by the converter |
| exp_code_i | input | 12 | Ideal code for the same sample |
| qry_code_i | input | 12 | Code whose estimate is requested |
| qry_inl_o | output | 20 | Signed estimate, 4 fractional bits |
| ready_o | output | 1 | All terms computed |

## Verification
Several properties are checked on every cycle:
- Each accepted sample bumps the count of the segment it addresses.
- Each quotient the divider returns is the exact floor of its dividend over the segment count.
- A start always drops the ready flag.
- The ready flag holds until a start, and rises only out of the computing phase.

Other behaviours can only be shown by the bench's scenarios, which compare queried estimates against a scoreboard model:
- The truncation of negative means toward zero.
- Zero terms for empty segments.
- Samples ignored during computation and after ready.
- Clearing by start.

// File: rtl/seg_inl_pkg.sv
package seg_inl_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DIVIDE  = 2'd1,
        ST_READY   = 2'd2
    } est_state_e;
endpackage

// File: rtl/seg_bank.sv
// Sum and count store for the segments of one code field.
module seg_bank #(
    parameter int FW    = 4,
    parameter int DIF_W = 13,
    parameter int CNT_W = 13,
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    en_i,
    input  logic [FW-1:0]           idx_i,
    input  logic signed [DIF_W-1:0] diff_i,
    input  logic [FW-1:0]           rd_idx_i,
    output logic signed [ACC_W-1:0] rd_acc_o,
    output logic [CNT_W-1:0]        rd_cnt_o
);
    localparam int NSEG = 1 << FW;

    typedef struct packed {
        logic [NSEG-1:0][ACC_W-1:0] acc;
        logic [NSEG-1:0][CNT_W-1:0] cnt;
    } bank_t;

    bank_t s_d, s_q;
    logic signed [ACC_W-1:0] diff_x;

    assign diff_x = ACC_W'(diff_i);

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else if (en_i) begin
            s_d.acc[idx_i] = $signed(s_q.acc[idx_i]) + diff_x;
            s_d.cnt[idx_i] = s_q.cnt[idx_i] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_acc_o = $signed(s_q.acc[rd_idx_i]);
    assign rd_cnt_o = s_q.cnt[rd_idx_i];

    // R1: an accepted sample adds one to the count of its segment
    p_cnt_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> (s_q.cnt[$past(idx_i)] == $past(s_q.cnt[idx_i]) + CNT_W'(1)));
endmodule

// File: rtl/seg_div.sv
// Shared restoring divider, one quotient bit per cycle.
module seg_div #(
    parameter int N_W = 30,
    parameter int D_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           abort_i,
    input  logic           go_i,
    input  logic [N_W-1:0] num_i,
    input  logic [D_W-1:0] den_i,
    output logic           done_o,
    output logic [N_W-1:0] quo_o
);
    localparam int SW = $clog2(N_W + 1);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [SW-1:0]  step;
        logic [D_W-1:0] rem;
        logic [D_W-1:0] den;
        logic [N_W-1:0] quo;
    } div_t;

    div_t s_d, s_q;
    logic [D_W:0] shifted, sub;

    assign shifted = {s_q.rem, s_q.quo[N_W-1]};
    assign sub     = shifted - {1'b0, s_q.den};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (abort_i) begin
            s_d.busy = 1'b0;
        end else if (go_i && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.step = '0;
            s_d.rem  = '0;
            s_d.den  = den_i;
            s_d.quo  = num_i;
        end else if (s_q.busy) begin
            if (shifted >= {1'b0, s_q.den}) begin
                s_d.rem = sub[D_W-1:0];
                s_d.quo = {s_q.quo[N_W-2:0], 1'b1};
            end else begin
                s_d.rem = shifted[D_W-1:0];
                s_d.quo = {s_q.quo[N_W-2:0], 1'b0};
            end
            s_d.step = s_q.step + SW'(1);
            if (s_q.step == SW'(N_W - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
    assign quo_o  = s_q.quo;
endmodule

// File: rtl/seg_inl_est.sv
module seg_inl_est
    import seg_inl_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int FRAC_W = 4,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              done_i,
    input  logic              sample_vld_i,
    input  logic [CODE_W-1:0] act_code_i,
    input  logic [CODE_W-1:0] exp_code_i,
    input  logic [CODE_W-1:0] qry_code_i,
    output logic [CODE_W+FRAC_W+3:0] qry_inl_o,
    output logic              ready_o
);
    localparam int NFLD  = 3;
    localparam int FW    = CODE_W / NFLD;
    localparam int NSEG  = 1 << FW;
    localparam int NTERM = NFLD * NSEG;
    localparam int KW    = $clog2(NTERM);
    localparam int ACC_W = CODE_W + 1 + CNT_W;
    localparam int NUM_W = ACC_W + FRAC_W;
    localparam int RES_W = CODE_W + FRAC_W + 2;
    localparam int OUT_W = RES_W + 2;
    localparam int PW    = NUM_W + CNT_W + 1;

    typedef struct packed {
        est_state_e                 state;
        logic [KW-1:0]              k;
        logic                       launched;
        logic [NTERM-1:0][RES_W-1:0] res;
        logic [OUT_W-1:0]           qry;
    } est_t;

    est_t s_d, s_q;

    logic signed [CODE_W:0]  diff_w;
    logic                    bank_en;
    logic signed [ACC_W-1:0] bank_acc [NFLD];
    logic [CNT_W-1:0]        bank_cnt [NFLD];
    logic signed [ACC_W-1:0] sel_acc;
    logic [CNT_W-1:0]        sel_cnt;
    logic [ACC_W-1:0]        acc_mag;
    logic [NUM_W-1:0]        num_w;
    logic                    div_go, div_done;
    logic [NUM_W-1:0]        div_quo;
    logic signed [RES_W-1:0] term_w;
    logic signed [OUT_W-1:0] qsum;

    assign diff_w  = $signed({1'b0, exp_code_i}) - $signed({1'b0, act_code_i});
    assign bank_en = sample_vld_i && (s_q.state == ST_COLLECT);

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        seg_bank #(.FW(FW), .DIF_W(CODE_W + 1), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (start_i),
            .en_i     (bank_en),
            .idx_i    (act_code_i[g*FW +: FW]),
            .diff_i   (diff_w),
            .rd_idx_i (s_q.k[FW-1:0]),
            .rd_acc_o (bank_acc[g]),
            .rd_cnt_o (bank_cnt[g])
        );
    end

    always_comb begin
        sel_acc = '0;
        sel_cnt = '0;
        for (int g = 0; g < NFLD; g++) begin
            if (int'(s_q.k[KW-1:FW]) == g) begin
                sel_acc = bank_acc[g];
                sel_cnt = bank_cnt[g];
            end
        end
    end

    assign acc_mag = sel_acc[ACC_W-1] ? ACC_W'(-sel_acc) : ACC_W'(sel_acc);
    assign num_w   = {acc_mag, {FRAC_W{1'b0}}};

    seg_div #(.N_W(NUM_W), .D_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_i (start_i),
        .go_i    (div_go),
        .num_i   (num_w),
        .den_i   (sel_cnt),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    always_comb begin
        if (sel_cnt == '0)        term_w = '0;
        else if (sel_acc[ACC_W-1]) term_w = -$signed(div_quo[RES_W-1:0]);
        else                       term_w = $signed(div_quo[RES_W-1:0]);
    end

    always_comb begin
        qsum = '0;
        for (int g = 0; g < NFLD; g++) begin
            qsum = qsum + OUT_W'($signed(s_q.res[g*NSEG + int'(qry_code_i[g*FW +: FW])]));
        end
    end

    always_comb begin
        s_d     = s_q;
        div_go  = 1'b0;
        s_d.qry = qsum;
        case (s_q.state)
            ST_COLLECT: begin
                if (done_i) begin
                    s_d.state    = ST_DIVIDE;
                    s_d.k        = '0;
                    s_d.launched = 1'b0;
                end
            end
            ST_DIVIDE: begin
                if (!s_q.launched) begin
                    div_go       = 1'b1;
                    s_d.launched = 1'b1;
                end else if (div_done) begin
                    s_d.res[s_q.k] = term_w;
                    s_d.launched   = 1'b0;
                    if (s_q.k == KW'(NTERM - 1)) s_d.state = ST_READY;
                    else                         s_d.k     = s_q.k + KW'(1);
                end
            end
            default: ;
        endcase
        if (start_i) begin
            s_d.state    = ST_COLLECT;
            s_d.k        = '0;
            s_d.launched = 1'b0;
            s_d.res      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign qry_inl_o = s_q.qry;
    assign ready_o   = (s_q.state == ST_READY);

    // R2: quotient returned by the divider is floor(num / count)
    p_div_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done && s_q.launched && sel_cnt != '0) |->
            ((PW'(div_quo) * PW'(sel_cnt) <= PW'(num_w)) &&
             (PW'(num_w) < (PW'(div_quo) + PW'(1)) * PW'(sel_cnt))));
    // R5: start always drops ready
    p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !ready_o);
    // R7: ready holds until start
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> ready_o);
    // R7: ready only rises out of the computing phase
    p_rise_from_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(s_q.state) == ST_DIVIDE));
endmodule

// File: tb/sim_seg_inl_est.sv
module sim_seg_inl_est;
    localparam int CLK_P = 10;
    localparam int RDY_LIMIT = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, done_i = 1'b0, sample_vld_i = 1'b0;
    logic [11:0] act_code_i = '0, exp_code_i = '0, qry_code_i = '0;
    logic [19:0] qry_inl_o;
    logic        ready_o;

    int total = 0;
    int bad = 0;
    bit q_fire = 0;

    longint m_acc [3][16];
    int     m_cnt [3][16];
    longint exp_q [$];
    int     code_q [$];
    string  tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    seg_inl_est u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_i(done_i),
        .sample_vld_i(sample_vld_i), .act_code_i(act_code_i), .exp_code_i(exp_code_i),
        .qry_code_i(qry_code_i), .qry_inl_o(qry_inl_o), .ready_o(ready_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int f = 0; f < 3; f++)
            for (int s = 0; s < 16; s++) begin
                m_acc[f][s] = 0;
                m_cnt[f][s] = 0;
            end
    endtask

    function automatic longint m_term(input int f, input int s);
        if (m_cnt[f][s] == 0) return 0;
        return (m_acc[f][s] * 16) / m_cnt[f][s];
    endfunction

    function automatic longint m_inl(input int c);
        return m_term(0, c & 15) + m_term(1, (c >> 4) & 15) + m_term(2, (c >> 8) & 15);
    endfunction

    task automatic send(input int a, input int e, input bit counted);
        @(negedge clk);
        sample_vld_i = 1'b1;
        act_code_i = 12'(a);
        exp_code_i = 12'(e);
        if (counted)
            for (int f = 0; f < 3; f++) begin
                m_acc[f][(a >> (4*f)) & 15] += longint'(e) - longint'(a);
                m_cnt[f][(a >> (4*f)) & 15] += 1;
            end
    endtask

    task automatic idle_in();
        @(negedge clk);
        sample_vld_i = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); sample_vld_i = 1'b0; done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        model_clear();
    endtask

    // driver: pushes the expected estimate, the monitor compares it
    task automatic query(input int c, input string tag);
        @(negedge clk);
        qry_code_i = 12'(c);
        exp_q.push_back(m_inl(c));
        code_q.push_back(c);
        tag_q.push_back(tag);
        q_fire = 1;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            if (q_fire) begin
                longint ev;
                int cc;
                string tg;
                q_fire = 0;
                #(CLK_P/4);
                ev = exp_q.pop_front();
                cc = code_q.pop_front();
                tg = tag_q.pop_front();
                check(longint'($signed(qry_inl_o)) == ev,
                      $sformatf("%s query code=%0h", tg, cc),
                      longint'($signed(qry_inl_o)), ev);
            end
        end
    end

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!ready_o && n < RDY_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(ready_o == 1'b1, tag, n, RDY_LIMIT);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready_o == 1'b0, "R9 ready after reset", ready_o, 0);
        query(0, "R9 reset term");
        query('hABC, "R9 reset term");

        // constant offset of +3 on every code
        for (int c = 0; c < 4096; c++) send(c, (c + 3) & 'hFFF, 1);
        idle_in();
        pulse_done();
        check(ready_o == 1'b0, "R7 ready low just after done", ready_o, 0);
        wait_ready("R7 ready within limit");
        query('h000, "R1 R4 offset ramp");
        query('h5A3, "R1 R4 offset ramp");
        query('hFFF, "R4 offset ramp");

        // irregular errors, high field limited to 0..7, extra pass
        pulse_start();
        check(ready_o == 1'b0, "R5 ready cleared", ready_o, 0);
        query('h345, "R5 terms cleared");
        for (int c = 0; c < 2048; c++) send(c, (c + ((c * 7) % 11) - 5 - (c >> 9)) & 'hFFF, 1);
        for (int c = 1; c < 2048; c += 3) send(c, (c + ((c * 5) % 7) - 4) & 'hFFF, 1);
        idle_in();
        pulse_done();
        for (int i = 0; i < 6; i++) send(100 + i * 300, 4000, 0);
        idle_in();
        pulse_done();
        wait_ready("R6 R7 ready after computation");
        for (int i = 0; i < 16; i++) query((i * 'h1F3 + 7) & 'hFFF, "R2 R6 mean per segment");
        query('h000, "R2 low codes");
        query('h7FF, "R2 top populated");
        query('h800, "R3 empty high segment");
        query('hFFF, "R3 empty high segment");
        for (int i = 0; i < 5; i++) send(i * 9, 4095, 0);
        idle_in();
        check(ready_o == 1'b1, "R7 ready held", ready_o, 1);
        query('h123, "R8 no change after ready");
        query('h9A5, "R8 no change after ready");

        // empty run
        pulse_start();
        pulse_done();
        wait_ready("R3 ready on empty run");
        query('h6D2, "R3 all segments empty");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule